// File: doc/BRIEF.md
# Latched BCD Seven-Segment LCD Digit Driver

This block turns a 4-bit BCD digit, weighted 8-4-2-1 from the top input bit down to the bottom one, into the seven segment lines of one liquid crystal digit. A clocked hold register sits in front of the decoder. While the load control is high, it takes a new code on every rising clock edge. While the load control is low, it keeps the last code it took. Codes ten to fifteen give a dark digit, not hex letters.

After the decoder, a blanking input can darken the digit whatever code is held. A phase input then inverts all seven lines. A backplane generator in the same clock domain makes a 50 % square wave whose half period is a parameter. The integrator routes that wave to the phase input and to the display's common plane. A lit segment then always swings against the common plane and an unlit segment swings with it, so the glass sees no DC.

Top module: `lcd_digit_driver`

## Requirements
- R1: While `load_en` is high, each rising clock edge stores `bcd_in`, and `seg` shows the stored code from that edge onward.
- R2: While `load_en` is low, the stored code does not change for any value of `bcd_in`, so `seg` stays the same as long as `blank` and `phase` stay the same.
- R3: With `blank` and `phase` low, stored codes 0 to 9 drive `seg` (bit 0 = a top, 1 = b upper right, 2 = c lower right, 3 = d bottom, 4 = e lower left, 5 = f upper left, 6 = g middle) to 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R4: With `blank` and `phase` low, stored codes 10 to 15 drive `seg` to 0x00.
- R5: With `blank` high and `phase` low, `seg` is 0x00 whatever the stored code, `load_en` and `bcd_in` are.
- R6: With `phase` high, `seg` is the bitwise inverse of its value with `phase` low under the same other inputs. A blanked digit therefore gives 0x7F.
- R7: `backplane` is low out of reset and toggles every HALF_PERIOD clock cycles, so its high and low runs are both HALF_PERIOD cycles long.
- R8: During reset the stored code is 15, so `seg` is 0x00 with `phase` low, and `backplane` is low.
- R9: With `phase` tied to `backplane`, each lit segment is the inverse of `backplane` and each unlit segment equals it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the hold register and the backplane divider |
| rst_n | input | 1 | Asynchronous reset, active low |
| bcd_in | input | 4 | BCD digit, bit 3 weighs 8 |
| load_en | input | 1 | High: the register takes `bcd_in` on each edge; low: it holds |
| blank | input | 1 | High: digit forced dark |
| phase | input | 1 | High: all segment lines inverted |
| seg | output | 7 | Segment lines, bit 0 = a through bit 6 = g |
| backplane | output | 1 | Square wave for the common plane and the phase input |

## Verification
The only state in the block is the stored code and the divider. A stored code that is wrong shows on `seg` in the same cycle as a wrong digit pattern, unless the digit is blanked. Such a fault can stay hidden while `blank` is high, so the held-code checks run with blanking off. A divider fault shows as a backplane run that is not HALF_PERIOD cycles long, starting from the first toggle after reset.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_N  = 7;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_N-1:0]  seg_t;

  // Reset value of the hold register: an out-of-range code, shown dark
  localparam code_t RESET_CODE = code_t'(15);

  // Segment order: bit0=a ... bit6=g
  function automatic seg_t digit_pattern(input code_t code);
    seg_t p;
    case (code)
      code_t'(0): p = 7'b0111111;
      code_t'(1): p = 7'b0000110;
      code_t'(2): p = 7'b1011011;
      code_t'(3): p = 7'b1001111;
      code_t'(4): p = 7'b1100110;
      code_t'(5): p = 7'b1101101;
      code_t'(6): p = 7'b1111101;
      code_t'(7): p = 7'b0000111;
      code_t'(8): p = 7'b1111111;
      code_t'(9): p = 7'b1101111;
      default:    p = '0;
    endcase
    return p;
  endfunction

  function automatic seg_t apply_phase(input seg_t base, input logic ph);
    return ph ? ~base : base;
  endfunction
endpackage

// File: rtl/lcd_code_hold.sv
module lcd_code_hold
  import lcd_seg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  code_t code_in,
  output code_t code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= RESET_CODE;
    else if (load_en) code_q <= code_in;
  end
endmodule

// File: rtl/lcd_seg_shaper.sv
module lcd_seg_shaper
  import lcd_seg_pkg::*;
(
  input  code_t code,
  input  logic  blank,
  input  logic  phase,
  output seg_t  seg
);
  seg_t base;
  always_comb begin
    base = blank ? '0 : digit_pattern(code);
    seg  = apply_phase(base, phase);
  end
endmodule

// File: rtl/lcd_backplane_gen.sv
module lcd_backplane_gen #(
  parameter int HALF_PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic wave
);
  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      wave <= ~wave;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_digit_driver.sv
module lcd_digit_driver #(
  parameter int HALF_PERIOD = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bcd_in,
  input  logic       load_en,
  input  logic       blank,
  input  logic       phase,
  output logic [6:0] seg,
  output logic       backplane
);
  import lcd_seg_pkg::*;

  code_t held_code;
  logic  bp_tick;

  lcd_code_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .code_in (bcd_in),
    .code_q  (held_code)
  );

  lcd_seg_shaper u_shape (
    .code  (held_code),
    .blank (blank),
    .phase (phase),
    .seg   (seg)
  );

  lcd_backplane_gen #(.HALF_PERIOD(HALF_PERIOD)) u_bp (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (bp_tick),
    .wave  (backplane)
  );
endmodule

module lcd_digit_driver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bcd_in,
  input logic       load_en,
  input logic       blank,
  input logic       phase,
  input logic [6:0] seg,
  input logic       backplane,
  input logic [3:0] held_code,
  input logic       bp_tick
);
  AST_LOAD_TAKES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> held_code == $past(bcd_in)); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (!($stable(blank) && $stable(phase)) || $stable(seg))); // R2
  AST_RANGE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (held_code > 4'd9 && !blank && !phase) |-> seg == 7'h00); // R4
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !phase) |-> seg == 7'h00); // R5
  AST_BLANK_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && phase) |-> seg == 7'h7F); // R6
  AST_BP_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (backplane != $past(backplane)) |-> $past(bp_tick)); // R7
  AST_BP_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    bp_tick |=> backplane != $past(backplane)); // R7
endmodule

bind lcd_digit_driver lcd_digit_driver_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bcd_in    (bcd_in),
  .load_en   (load_en),
  .blank     (blank),
  .phase     (phase),
  .seg       (seg),
  .backplane (backplane),
  .held_code (held_code),
  .bp_tick   (bp_tick)
);

// File: tb/lcd_digit_driver_bench.sv
module lcd_digit_driver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 3;

  // Expected dark-phase patterns per code, bit0=a .. bit6=g
  localparam logic [6:0] DIGITS [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bcd_in = 4'd8;
  logic       load_en = 1'b1;
  logic       blank = 1'b0;
  logic       ph_reg = 1'b0;
  logic       use_bp = 1'b0;
  logic       phase;
  logic [6:0] seg;
  logic       backplane;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign phase = use_bp ? backplane : ph_reg;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_digit_driver #(.HALF_PERIOD(HP)) u_lcd_digit_driver (
    .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .load_en(load_en),
    .blank(blank), .phase(phase), .seg(seg), .backplane(backplane)
  );

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] expect_seg(input int code, input logic b, input logic p);
    logic [6:0] base;
    base = b ? 7'h00 : DIGITS[code];
    return p ? ~base : base;
  endfunction

  task automatic load_code(input int code);
    @(negedge clk);
    bcd_in = 4'(code);
    load_en = 1'b1;
    @(posedge clk);
    #1;
    load_en = 1'b0;
  endtask

  initial begin
    // R8: reset state
    @(negedge clk);
    check("R8 seg in reset", seg, 7'h00);
    check("R8 backplane in reset", {6'b0, backplane}, 7'h00);
    @(negedge clk);
    rst_n = 1'b1;
    load_en = 1'b0;

    // Table sweep: R1, R3, R4, R5, R6
    for (int c = 0; c < 16; c++) begin
      load_code(c);
      for (int b = 0; b < 2; b++) begin
        for (int p = 0; p < 2; p++) begin
          blank = b[0];
          ph_reg = p[0];
          #1;
          if (b == 1)      check(p ? "R6 blank inverted" : "R5 blank", seg, expect_seg(c, b[0], p[0]));
          else if (p == 1) check("R6 phase inversion", seg, expect_seg(c, 1'b0, 1'b1));
          else if (c < 10) check("R3 R1 digit pattern", seg, expect_seg(c, 1'b0, 1'b0));
          else             check("R4 out of range dark", seg, 7'h00);
        end
      end
      blank = 1'b0;
      ph_reg = 1'b0;
    end

    // R2: held code survives data changes while load_en is low
    load_code(2);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      bcd_in = 4'(k);
      @(posedge clk);
      #1;
      check("R2 hold while latched", seg, 7'h5B);
    end

    // R1: new code appears right after the loading edge
    @(negedge clk);
    bcd_in = 4'd7;
    load_en = 1'b1;
    #1;
    check("R1 before edge still old", seg, 7'h5B);
    @(posedge clk);
    #1;
    check("R1 after edge new code", seg, 7'h07);
    load_en = 1'b0;

    // R5: blank overrides while loading
    @(negedge clk);
    blank = 1'b1;
    load_en = 1'b1;
    bcd_in = 4'd0;
    @(posedge clk);
    #1;
    check("R5 blank during load", seg, 7'h00);
    @(negedge clk);
    blank = 1'b0;
    load_en = 1'b0;
    #1;
    check("R1 code taken under blank", seg, 7'h3F);

    // R7: backplane run lengths
    begin
      logic prev;
      int run;
      int seen;
      prev = backplane;
      run = 0;
      seen = 0;
      for (int i = 0; i < 40 && seen < 5; i++) begin
        @(negedge clk);
        if (backplane !== prev) begin
          if (seen > 0) check("R7 backplane run length", 7'(run), 7'(HP));
          seen++;
          run = 1;
          prev = backplane;
        end else begin
          run++;
        end
      end
      check("R7 toggles seen", 7'(seen), 7'd5);
    end

    // R9: phase tied to backplane, digit 1 (b,c lit, others unlit)
    load_code(1);
    use_bp = 1'b1;
    for (int i = 0; i < 2*HP + 2; i++) begin
      @(negedge clk);
      check("R9 antiphase drive", seg,
            backplane ? 7'b1111001 : 7'b0000110);
    end
    use_bp = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule